// File: doc/BRIEF.md
# Committed Store Drain Unit

This block holds the stores of one thread in a circular queue and sends them to the data cache strictly in program order. A store is written at the tail together with its physical address and an instruction tag. It then waits, marked as still speculative, until the commit logic clears that mark by naming the store's slot. On every cycle the unit looks at the oldest stores, up to a per-cycle quantum given by the caller. It presents their addresses to the cache port and issues the longest run, starting at the head, in which every store is committed and its address is reported accessible.

The scan stops at the first store that is still speculative or that the cache cannot take. No younger store passes it. The issued stores leave the head of the queue. The unit returns the unused part of the quantum, stamps the issue with a free-running cycle count, and keeps a running total of queue reads, one for each issued store. Each lane of the cache port answers for the address shown on the same lane.

Top module: `store_drain_unit`

## Requirements
- R1: `enq_ready` is high exactly when fewer than DEPTH stores are held. A store offered while `enq_ready` is low is dropped and leaves the queue contents unchanged.
- R2: Each accepted store takes the next slot number in sequence, modulo DEPTH, starting at 0 after reset, and shows that number on `enq_slot` in the cycle it is offered. The store enters as uncommitted. A pulse on `cmt_valid` marks the store in `cmt_slot` as committed. An uncommitted store is never issued.
- R3: Issue follows queue order. Lane k issues only when lanes 0 to k-1 issue in the same cycle, so `iss_valid` always has the form of low-order ones followed by zeros.
- R4: Lane k issues only when `probe_ok[k]` is high. A low answer ends issue for that cycle at that lane.
- R5: The number of stores issued in a cycle never exceeds `quant_in`, LANES, or the number of stores held.
- R6: `quant_left` equals `quant_in` minus the number of stores issued in the same cycle.
- R7: Lane k of `probe_addr` and `iss_tag` carries the address and tag of the k-th oldest stored entry. Issued stores are removed from the head, so the next cycle presents the stores that follow them.
- R8: `iss_stamp` equals the number of rising clock edges since reset was released.
- R9: `rd_count` grows by the number of stores issued in each cycle.
- R10: After reset the queue is empty, nothing issues, `enq_ready` is high, `rd_count` is 0, and `quant_left` equals `quant_in`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enq_valid | input | 1 | Offer a new store at the tail |
| enq_addr | input | ADDR_W | Physical address of the offered store |
| enq_tag | input | TAG_W | Instruction tag of the offered store |
| enq_ready | output | 1 | Queue has room |
| enq_slot | output | PTR_W | Slot the offered store will occupy |
| cmt_valid | input | 1 | Commit pulse |
| cmt_slot | input | PTR_W | Slot of the store that commits |
| quant_in | input | QW | Issue budget for this cycle |
| probe_addr | output | LANES*ADDR_W | Addresses of the oldest stores, lane 0 oldest |
| probe_ok | input | LANES | Cache port accepts the address on each lane |
| iss_valid | output | LANES | Per-lane issue this cycle |
| iss_tag | output | LANES*TAG_W | Tags of the oldest stores, per lane |
| iss_stamp | output | CYC_W | Cycle stamp for this cycle's issues |
| quant_left | output | QW | Unused part of the budget |
| rd_count | output | CNT_W | Running total of issued stores |

## Verification
The assertions assume that commit pulses name only slots that hold a stored, still uncommitted store. They also assume a commit never targets the slot that is being written in the same cycle. The bench keeps its own ordered list of held stores and picks commit targets only from the uncommitted entries in that list. The cache port answers are a per-lane mask that sweeps every pattern together with every quantum value. The enqueue rate changes by phase, so the queue fills to the full boundary, is offered stores while full, and later drains to empty.

// File: rtl/sdu_pkg.sv
`timescale 1ns/1ps
package sdu_pkg;

  // Circular slot arithmetic: slot reached after 'step' moves from 'base'.
  function automatic int slot_after(int base, int step, int depth);
    return (base + step) % depth;
  endfunction

  // Budget remaining after 'used' issues.
  function automatic int quant_rest(int q, int used);
    return (q > used) ? q - used : 0;
  endfunction

endpackage

// File: rtl/sdu_store_q.sv
`timescale 1ns/1ps
module sdu_store_q
  import sdu_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 12,
  parameter int TAG_W  = 6,
  parameter int LANES  = 3,
  parameter int QW     = $clog2(LANES + 1),
  parameter int PTR_W  = $clog2(DEPTH),
  parameter int OCC_W  = $clog2(DEPTH + 1)
)(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    push,
  input  logic [ADDR_W-1:0]       push_addr,
  input  logic [TAG_W-1:0]        push_tag,
  input  logic                    cmt,
  input  logic [PTR_W-1:0]        cmt_slot,
  input  logic [QW-1:0]           pop_n,
  output logic [LANES*ADDR_W-1:0] lane_addr,
  output logic [LANES*TAG_W-1:0]  lane_tag,
  output logic [LANES-1:0]        lane_ready,
  output logic [OCC_W-1:0]        occ,
  output logic [PTR_W-1:0]        tail
);

  logic [ADDR_W-1:0] addr_mem [DEPTH];
  logic [TAG_W-1:0]  tag_mem  [DEPTH];
  logic [DEPTH-1:0]  spec_q;
  logic [PTR_W-1:0]  head_q, tail_q;
  logic [OCC_W-1:0]  occ_q;

  always_ff @(posedge clk) begin
    if (push) begin
      addr_mem[tail_q] <= push_addr;
      tag_mem[tail_q]  <= push_tag;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head_q <= '0;
      tail_q <= '0;
      occ_q  <= '0;
      spec_q <= '0;
    end else begin
      if (cmt)  spec_q[cmt_slot] <= 1'b0;
      if (push) spec_q[tail_q]   <= 1'b1;
      head_q <= PTR_W'(slot_after(int'(head_q), int'(pop_n), DEPTH));
      if (push) tail_q <= PTR_W'(slot_after(int'(tail_q), 1, DEPTH));
      occ_q <= occ_q + OCC_W'(push) - OCC_W'(pop_n);
    end
  end

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic [PTR_W-1:0] lane_slot;
    assign lane_slot = PTR_W'(slot_after(int'(head_q), k, DEPTH));
    assign lane_addr[k*ADDR_W +: ADDR_W] = addr_mem[lane_slot];
    assign lane_tag[k*TAG_W +: TAG_W]    = tag_mem[lane_slot];
    assign lane_ready[k] = (int'(occ_q) > k) && !spec_q[lane_slot];
  end

  assign occ  = occ_q;
  assign tail = tail_q;

endmodule

// File: rtl/sdu_issue_pick.sv
`timescale 1ns/1ps
module sdu_issue_pick
  import sdu_pkg::*;
#(
  parameter int LANES = 3,
  parameter int QW    = $clog2(LANES + 1)
)(
  input  logic [QW-1:0]    quant_in,
  input  logic [LANES-1:0] lane_ready,
  input  logic [LANES-1:0] lane_port_ok,
  output logic [LANES-1:0] go,
  output logic [QW-1:0]    n_go,
  output logic [QW-1:0]    quant_left
);

  logic [LANES:0] chain;
  assign chain[0] = 1'b1;

  for (genvar k = 0; k < LANES; k++) begin : g_pick
    assign go[k] = chain[k] && (int'(quant_in) > k) && lane_ready[k] && lane_port_ok[k];
    assign chain[k+1] = go[k];
  end

  always_comb begin
    int cnt;
    cnt = 0;
    for (int i = 0; i < LANES; i++) cnt += int'(go[i]);
    n_go = QW'(cnt);
  end

  assign quant_left = QW'(quant_rest(int'(quant_in), int'(n_go)));

endmodule

// File: rtl/sdu_tally.sv
`timescale 1ns/1ps
module sdu_tally #(
  parameter int QW    = 2,
  parameter int CYC_W = 16,
  parameter int CNT_W = 16
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [QW-1:0]    n_go,
  output logic [CYC_W-1:0] cyc,
  output logic [CNT_W-1:0] reads
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cyc   <= '0;
      reads <= '0;
    end else begin
      cyc   <= cyc + 1'b1;
      reads <= reads + CNT_W'(n_go);
    end
  end

endmodule

// File: rtl/store_drain_unit.sv
`timescale 1ns/1ps
module store_drain_unit #(
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 12,
  parameter int TAG_W  = 6,
  parameter int LANES  = 3,
  parameter int CYC_W  = 16,
  parameter int CNT_W  = 16,
  localparam int QW    = $clog2(LANES + 1),
  localparam int PTR_W = $clog2(DEPTH),
  localparam int OCC_W = $clog2(DEPTH + 1)
)(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    enq_valid,
  input  logic [ADDR_W-1:0]       enq_addr,
  input  logic [TAG_W-1:0]        enq_tag,
  output logic                    enq_ready,
  output logic [PTR_W-1:0]        enq_slot,
  input  logic                    cmt_valid,
  input  logic [PTR_W-1:0]        cmt_slot,
  input  logic [QW-1:0]           quant_in,
  output logic [LANES*ADDR_W-1:0] probe_addr,
  input  logic [LANES-1:0]        probe_ok,
  output logic [LANES-1:0]        iss_valid,
  output logic [LANES*TAG_W-1:0]  iss_tag,
  output logic [CYC_W-1:0]        iss_stamp,
  output logic [QW-1:0]           quant_left,
  output logic [CNT_W-1:0]        rd_count
);

  // Named internal events
  logic             push_fire;
  logic [QW-1:0]    pop_n;
  logic [LANES-1:0] lane_ready;
  logic [OCC_W-1:0] occ;

  assign enq_ready = int'(occ) < DEPTH;
  assign push_fire = enq_valid && enq_ready;

  sdu_store_q #(
    .DEPTH(DEPTH), .ADDR_W(ADDR_W), .TAG_W(TAG_W), .LANES(LANES),
    .QW(QW), .PTR_W(PTR_W), .OCC_W(OCC_W)
  ) u_queue (
    .clk        (clk),
    .rst_n      (rst_n),
    .push       (push_fire),
    .push_addr  (enq_addr),
    .push_tag   (enq_tag),
    .cmt        (cmt_valid),
    .cmt_slot   (cmt_slot),
    .pop_n      (pop_n),
    .lane_addr  (probe_addr),
    .lane_tag   (iss_tag),
    .lane_ready (lane_ready),
    .occ        (occ),
    .tail       (enq_slot)
  );

  sdu_issue_pick #(.LANES(LANES), .QW(QW)) u_pick (
    .quant_in     (quant_in),
    .lane_ready   (lane_ready),
    .lane_port_ok (probe_ok),
    .go           (iss_valid),
    .n_go         (pop_n),
    .quant_left   (quant_left)
  );

  sdu_tally #(.QW(QW), .CYC_W(CYC_W), .CNT_W(CNT_W)) u_tally (
    .clk   (clk),
    .rst_n (rst_n),
    .n_go  (pop_n),
    .cyc   (iss_stamp),
    .reads (rd_count)
  );

endmodule

// File: rtl/sdu_checker.sv
`timescale 1ns/1ps
module sdu_checker #(
  parameter int DEPTH = 8,
  parameter int LANES = 3,
  parameter int QW    = 2,
  parameter int OCC_W = 4,
  parameter int CYC_W = 16,
  parameter int CNT_W = 16
)(
  input logic             clk,
  input logic             rst_n,
  input logic             enq_valid,
  input logic             enq_ready,
  input logic [OCC_W-1:0] occ,
  input logic [LANES-1:0] iss_valid,
  input logic [LANES-1:0] probe_ok,
  input logic [QW-1:0]    quant_in,
  input logic [QW-1:0]    quant_left,
  input logic [CNT_W-1:0] rd_count,
  input logic [CYC_W-1:0] iss_stamp
);

  p_full_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (enq_valid && !enq_ready) |=> (occ <= $past(occ)));

  p_occ_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
    int'(occ) <= DEPTH);

  p_in_order_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((LANES'(iss_valid + 1'b1) & iss_valid) == '0));

  for (genvar k = 0; k < LANES; k++) begin : g_port
    p_port_ok_r4: assert property (@(posedge clk) disable iff (!rst_n)
      iss_valid[k] |-> probe_ok[k]);
  end

  p_quant_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(iss_valid) <= int'(quant_in));

  p_held_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(iss_valid) <= int'(occ));

  p_left_r6: assert property (@(posedge clk) disable iff (!rst_n)
    int'(quant_left) + $countones(iss_valid) == int'(quant_in));

  p_stamp_r8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> iss_stamp == CYC_W'($past(iss_stamp) + 1'b1));

  p_reads_r9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> rd_count == CNT_W'($past(rd_count) + CNT_W'($past($countones(iss_valid)))));

endmodule

bind store_drain_unit sdu_checker #(
  .DEPTH(DEPTH), .LANES(LANES), .QW(QW), .OCC_W(OCC_W), .CYC_W(CYC_W), .CNT_W(CNT_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .enq_valid  (enq_valid),
  .enq_ready  (enq_ready),
  .occ        (occ),
  .iss_valid  (iss_valid),
  .probe_ok   (probe_ok),
  .quant_in   (quant_in),
  .quant_left (quant_left),
  .rd_count   (rd_count),
  .iss_stamp  (iss_stamp)
);

// File: tb/tb_store_drain_unit.sv
`timescale 1ns/1ps
module tb_store_drain_unit;

  localparam int DEPTH  = 8;
  localparam int ADDR_W = 12;
  localparam int TAG_W  = 6;
  localparam int LANES  = 3;
  localparam int CYC_W  = 16;
  localparam int CNT_W  = 16;
  localparam int QW     = $clog2(LANES + 1);
  localparam int PTR_W  = $clog2(DEPTH);
  localparam int NCYC   = 3000;

  logic                    clk = 1'b0;
  logic                    rst_n;
  logic                    enq_valid;
  logic [ADDR_W-1:0]       enq_addr;
  logic [TAG_W-1:0]        enq_tag;
  logic                    enq_ready;
  logic [PTR_W-1:0]        enq_slot;
  logic                    cmt_valid;
  logic [PTR_W-1:0]        cmt_slot;
  logic [QW-1:0]           quant_in;
  logic [LANES*ADDR_W-1:0] probe_addr;
  logic [LANES-1:0]        probe_ok;
  logic [LANES-1:0]        iss_valid;
  logic [LANES*TAG_W-1:0]  iss_tag;
  logic [CYC_W-1:0]        iss_stamp;
  logic [QW-1:0]           quant_left;
  logic [CNT_W-1:0]        rd_count;

  always #10 clk = ~clk;

  store_drain_unit #(
    .DEPTH(DEPTH), .ADDR_W(ADDR_W), .TAG_W(TAG_W), .LANES(LANES),
    .CYC_W(CYC_W), .CNT_W(CNT_W)
  ) dut (.*);

  typedef struct {
    int addr;
    int tag;
    int slot;
    bit cmt;
  } ent_t;

  ent_t mq[$];
  int   checks = 0;
  int   fails  = 0;
  bit   done   = 1'b0;
  int unsigned rng = 32'h1234_5678;

  function automatic int unsigned next_rand();
    rng ^= rng << 13;
    rng ^= rng >> 17;
    rng ^= rng << 5;
    return rng;
  endfunction

  task automatic chk(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int enq_total = 0;
    int exp_reads = 0;
    int exp_stamp = 0;
    rst_n = 1'b0; enq_valid = 1'b0; enq_addr = '0; enq_tag = '0;
    cmt_valid = 1'b0; cmt_slot = '0; quant_in = QW'(2); probe_ok = '1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R10: reset state
    chk("R10 enq_ready", enq_ready, 1);
    chk("R10 iss_valid", iss_valid, 0);
    chk("R10 rd_count", rd_count, 0);
    chk("R10 quant_left", quant_left, 2);
    chk("R10 enq_slot", enq_slot, 0);
    rst_n = 1'b1;

    for (int c = 0; c < NCYC; c++) begin
      int unsigned r;
      int q, mask, n, lim, cidx;
      string why;
      @(negedge clk);
      exp_stamp++;
      r = next_rand();
      q    = c % 4;
      mask = (c / 4) % 8;
      quant_in = QW'(q);
      probe_ok = LANES'(mask);
      if (c < 400)      enq_valid = (r % 4) != 0;
      else if (c < 800) enq_valid = (r % 6) == 0;
      else              enq_valid = (r % 2) != 0;
      enq_addr = ADDR_W'(r >> 12);
      enq_tag  = TAG_W'(c);
      // pick an uncommitted entry for commit
      cidx = -1;
      if ((c < 400) ? ((r >> 4) % 8 == 0) : ((r >> 4) % 3 != 0)) begin
        int unc = 0;
        foreach (mq[i]) if (!mq[i].cmt) unc++;
        if (unc > 0) begin
          int pick = int'((r >> 8) % unc);
          foreach (mq[i]) if (!mq[i].cmt) begin
            if (pick == 0 && cidx < 0) cidx = i;
            pick--;
          end
        end
      end
      cmt_valid = cidx >= 0;
      cmt_slot  = (cidx >= 0) ? PTR_W'(mq[cidx].slot) : '0;
      #2;

      // expected issue count and reason for stopping
      lim = (q < LANES) ? q : LANES;
      n = 0; why = "R3";
      while (1) begin
        if (n >= lim)              begin why = "R5 quantum"; break; end
        if (n >= mq.size())        begin why = "R5 empty"; break; end
        if (!mq[n].cmt)            begin why = "R2 uncommitted"; break; end
        if (!mask[n])              begin why = "R4 port"; break; end
        n++;
      end

      chk("R1 enq_ready", enq_ready, mq.size() < DEPTH);
      chk("R2 enq_slot", enq_slot, enq_total % DEPTH);
      chk({"iss_valid ", why}, iss_valid, (1 << n) - 1);
      chk("R3 prefix form", ((iss_valid + 1) & iss_valid) & ((1 << LANES) - 1), 0);
      chk("R6 quant_left", quant_left, q - n);
      chk("R8 iss_stamp", iss_stamp, exp_stamp % (1 << CYC_W));
      chk("R9 rd_count", rd_count, exp_reads % (1 << CNT_W));
      for (int k = 0; k < LANES; k++) begin
        if (k < mq.size()) begin
          chk("R7 lane addr", probe_addr[k*ADDR_W +: ADDR_W], mq[k].addr);
          chk("R7 lane tag", iss_tag[k*TAG_W +: TAG_W], mq[k].tag);
        end
      end

      // model update for the coming edge
      if (cidx >= 0) mq[cidx].cmt = 1'b1;
      for (int i = 0; i < n; i++) void'(mq.pop_front());
      exp_reads += n;
      if (enq_valid && (mq.size() + n) < DEPTH + n && enq_ready) begin
        ent_t e;
        e.addr = int'(enq_addr); e.tag = int'(enq_tag);
        e.slot = enq_total % DEPTH; e.cmt = 1'b0;
        mq.push_back(e);
        enq_total++;
      end
    end

    @(negedge clk);
    enq_valid = 1'b0; cmt_valid = 1'b0;
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule